// File: doc/BRIEF.md
# Grouped Fixed-Priority Channel Arbiter

This block decides which requesting DMA channel owns the shared bus next. Every channel sits in one of four priority levels, fixed by its index: the level is index bits 3:2, so the level pattern repeats every 16 channels, and a channel 16 positions away shares the same level. The arbiter always serves the best level that has a request. Among the channels of that level it rotates, so no channel in the level is starved.

A grant is registered and stays put until the bus signals completion with `done_i`. The cycle after `done_i` is a gap with no grant. Arbitration then runs again on the requests present in that gap cycle. The channel count is a parameter and defaults to 32.

Top module: `grp_prio_arb`

## Requirements
- R1: After reset, `gnt_o` is all zeros, `gnt_vld_o` is low and `gnt_idx_o` is 0.
- R2: Channel i belongs to level (i mod 16) / 4, which is index bits 3:2. Level 0 is the highest. A grant always goes to a channel of the highest level that has a request, so channel 16 (level 0) wins over channel 4 (level 1).
- R3: Each level keeps its own round-robin pointer, which stores the last channel granted in that level and starts at the top index after reset. The next grant in a level goes to the lowest-indexed requesting channel of that level above the pointer, or wraps to the lowest-indexed requesting channel of that level if none lies above it.
- R4: While `gnt_vld_o` is high and `done_i` is low, `gnt_o` and `gnt_idx_o` hold their values. This holds whatever `req_i` does, including when higher-priority requests arrive or all requests drop.
- R5: When `done_i` is high on an edge where `gnt_vld_o` is high, the grant clears on that edge. The next grant is loaded on the following edge from the `req_i` value at that time. `done_i` has no effect while no grant is held.
- R6: When no grant is held and `req_i` is all zeros, the next state is `gnt_o` = 0 and `gnt_vld_o` = 0.
- R7: `gnt_o` has at most one bit set. `gnt_vld_o` is high exactly when `gnt_o` is nonzero, and then `gnt_o[gnt_idx_o]` is set.
- R8: `NUM_CH` sets the channel count. A count that is not a multiple of 16 keeps the same index-to-level rule for the channels that exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_CH | Request vector, one bit per channel |
| done_i | input | 1 | Bus completion for the current grant |
| gnt_o | output | NUM_CH | One-hot grant |
| gnt_idx_o | output | $clog2(NUM_CH) | Encoded granted channel |
| gnt_vld_o | output | 1 | A grant is held |

## Verification
The bench builds two instances. The first uses the default of 32 channels, which covers the wrap of the level pattern at index 16 and the priority inversions it causes (16 over 4, 20 under 16). The second uses 20 channels, so level 0 has eight members and levels 1 to 3 have only four each. This exercises the level masks and the pointer wrap on a count that is not a power of two.

// File: rtl/grp_arb_pkg.sv
package grp_arb_pkg;
  localparam int LVL_N = 4;
  localparam int LVL_W = 2;

  // level is index bits 3:2, repeating every 16 channels
  function automatic logic [LVL_W-1:0] lvl_of(input int unsigned ch);
    logic [31:0] c;
    c = ch;
    return c[3:2];
  endfunction
endpackage

// File: rtl/rr_lvl_pick.sv
module rr_lvl_pick #(
  parameter int NUM_CH = 32,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              adv_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] ptr_q;
  logic             hi_hit, lo_hit;
  logic [IDX_W-1:0] hi_idx, lo_idx;

  always_comb begin
    hi_hit = 1'b0;
    lo_hit = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    for (int j = NUM_CH - 1; j >= 0; j--) begin
      if (req_i[j]) begin
        lo_hit = 1'b1;
        lo_idx = IDX_W'(j);
        if (j > int'(ptr_q)) begin
          hi_hit = 1'b1;
          hi_idx = IDX_W'(j);
        end
      end
    end
  end

  assign hit_o = lo_hit;
  assign idx_o = hi_hit ? hi_idx : lo_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= IDX_W'(NUM_CH - 1);
    else if (adv_i) ptr_q <= idx_o;
  end
endmodule

// File: rtl/lvl_pri_sel.sv
module lvl_pri_sel
  import grp_arb_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [LVL_N-1:0]            hit_i,
  input  logic [LVL_N-1:0][IDX_W-1:0] idx_i,
  output logic                        any_o,
  output logic [LVL_W-1:0]            lvl_o,
  output logic [IDX_W-1:0]            idx_o
);
  always_comb begin
    lvl_o = '0;
    idx_o = '0;
    for (int l = LVL_N - 1; l >= 0; l--) begin
      if (hit_i[l]) begin
        lvl_o = LVL_W'(l);
        idx_o = idx_i[l];
      end
    end
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/grp_prio_arb.sv
module grp_prio_arb
  import grp_arb_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              done_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic [IDX_W-1:0]  gnt_idx_o,
  output logic              gnt_vld_o
);
  logic [LVL_N-1:0][NUM_CH-1:0] lvl_req;
  logic [LVL_N-1:0]             lvl_hit;
  logic [LVL_N-1:0][IDX_W-1:0]  lvl_idx;
  logic [LVL_N-1:0]             lvl_adv;
  logic                         any;
  logic [LVL_W-1:0]             win_lvl;
  logic [IDX_W-1:0]             win_idx;
  logic                         load;

  logic [NUM_CH-1:0] gnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              vld_q;

  for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign lvl_req[l][i] = (lvl_of(i) == LVL_W'(l)) ? req_i[i] : 1'b0;
    end
    assign lvl_adv[l] = load && (win_lvl == LVL_W'(l));
    rr_lvl_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (lvl_req[l]),
      .adv_i  (lvl_adv[l]),
      .hit_o  (lvl_hit[l]),
      .idx_o  (lvl_idx[l])
    );
  end

  lvl_pri_sel #(.IDX_W(IDX_W)) u_sel (
    .hit_i (lvl_hit),
    .idx_i (lvl_idx),
    .any_o (any),
    .lvl_o (win_lvl),
    .idx_o (win_idx)
  );

  assign load = !vld_q && any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= '0;
      idx_q <= '0;
      vld_q <= 1'b0;
    end else if (vld_q) begin
      if (done_i) begin
        gnt_q <= '0;
        vld_q <= 1'b0;
      end
    end else if (load) begin
      gnt_q <= NUM_CH'(1) << win_idx;
      idx_q <= win_idx;
      vld_q <= 1'b1;
    end
  end

  assign gnt_o     = gnt_q;
  assign gnt_idx_o = idx_q;
  assign gnt_vld_o = vld_q;
endmodule

// File: rtl/grp_arb_chk.sv
module grp_arb_chk #(
  parameter int NUM_CH = 32,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] req_i,
  input logic              done_i,
  input logic [NUM_CH-1:0] gnt_o,
  input logic [IDX_W-1:0]  gnt_idx_o,
  input logic              gnt_vld_o
);
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R7
  AST_VLD_IFF_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o == (gnt_o != '0)); // R7
  AST_IDX_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |-> gnt_o[gnt_idx_o]); // R7
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_vld_o && !done_i) |=> ($stable(gnt_o) && $stable(gnt_idx_o))); // R4
  AST_DONE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_vld_o && done_i) |=> !gnt_vld_o); // R5
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_vld_o && req_i == '0) |=> !gnt_vld_o); // R6
endmodule

bind grp_prio_arb grp_arb_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .done_i    (done_i),
  .gnt_o     (gnt_o),
  .gnt_idx_o (gnt_idx_o),
  .gnt_vld_o (gnt_vld_o)
);

// File: tb/sim_grp_prio_arb.sv
module sim_grp_prio_arb;
  localparam int NA = 32;
  localparam int NB = 20;
  localparam int WA = $clog2(NA);
  localparam int WB = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NA-1:0] req_a = '0;
  logic [NB-1:0] req_b = '0;
  logic done_a = 1'b0, done_b = 1'b0;
  logic [NA-1:0] gnt_a;
  logic [NB-1:0] gnt_b;
  logic [WA-1:0] idx_a;
  logic [WB-1:0] idx_b;
  logic vld_a, vld_b;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  grp_prio_arb #(.NUM_CH(NA)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_a), .done_i(done_a),
    .gnt_o(gnt_a), .gnt_idx_o(idx_a), .gnt_vld_o(vld_a));

  grp_prio_arb #(.NUM_CH(NB)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_b), .done_i(done_b),
    .gnt_o(gnt_b), .gnt_idx_o(idx_b), .gnt_vld_o(vld_b));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // full grant on instance a: expect channel exp, then release
  task automatic grant_a(input logic [NA-1:0] req, input int exp, input string tag);
    @(negedge clk);
    req_a = req; done_a = 1'b0;
    tick();
    chk(vld_a && int'(idx_a) == exp && gnt_a == (NA'(1) << exp), tag, int'(idx_a), exp);
    @(negedge clk);
    done_a = 1'b1;
    tick();
    chk(!vld_a && gnt_a == '0, {tag, " R5 gap"}, int'(vld_a), 0);
    @(negedge clk);
    done_a = 1'b0; req_a = '0;
  endtask

  task automatic grant_b(input logic [NB-1:0] req, input int exp, input string tag);
    @(negedge clk);
    req_b = req; done_b = 1'b0;
    tick();
    chk(vld_b && int'(idx_b) == exp && gnt_b == (NB'(1) << exp), tag, int'(idx_b), exp);
    @(negedge clk);
    done_b = 1'b1;
    tick();
    chk(!vld_b, {tag, " R5 gap"}, int'(vld_b), 0);
    @(negedge clk);
    done_b = 1'b0; req_b = '0;
  endtask

  task automatic t_reset;
    #1;
    chk(gnt_a == '0 && !vld_a && idx_a == '0, "R1 reset a", int'(vld_a), 0);
    chk(gnt_b == '0 && !vld_b && idx_b == '0, "R1 reset b", int'(vld_b), 0);
  endtask

  task automatic t_idle;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(!vld_a && gnt_a == '0, "R6 idle", int'(gnt_a != '0), 0);
    end
    @(negedge clk);
    done_a = 1'b1;
    tick();
    chk(!vld_a, "R5 done ignored when idle", int'(vld_a), 0);
    @(negedge clk);
    done_a = 1'b0;
  endtask

  task automatic t_priority;
    grant_a((NA'(1) << 31) | (NA'(1) << 20) | (NA'(1) << 9), 20, "R2 level1 wins");
    grant_a((NA'(1) << 4) | (NA'(1) << 16), 16, "R2 ch16 beats ch4");
    grant_a((NA'(1) << 15) | (NA'(1) << 26), 26, "R2 level2 over level3");
  endtask

  task automatic t_rr;
    logic [NA-1:0] r;
    r = (NA'(1) << 1) | (NA'(1) << 3) | (NA'(1) << 17);
    grant_a(r, 17, "R3 after ptr 16");
    grant_a(r, 1, "R3 wrap");
    grant_a(r, 3, "R3 step");
    grant_a(r, 17, "R3 second lap");
  endtask

  task automatic t_hold;
    @(negedge clk);
    req_a = NA'(1) << 7;
    tick();
    chk(vld_a && idx_a == WA'(7), "R4 initial grant", int'(idx_a), 7);
    @(negedge clk);
    req_a = NA'(1) << 0 | NA'(1) << 7;
    tick();
    chk(vld_a && idx_a == WA'(7), "R4 hold vs higher req", int'(idx_a), 7);
    @(negedge clk);
    req_a = '0;
    tick();
    chk(vld_a && gnt_a == (NA'(1) << 7), "R4 hold with no req", int'(idx_a), 7);
    @(negedge clk);
    req_a = NA'(1) << 0; done_a = 1'b1;
    tick();
    chk(!vld_a, "R5 clear on done", int'(vld_a), 0);
    @(negedge clk);
    done_a = 1'b0;
    tick();
    chk(vld_a && idx_a == WA'(0), "R5 rearbitrate after gap", int'(idx_a), 0);
    @(negedge clk);
    done_a = 1'b1; req_a = '0;
    tick();
    @(negedge clk);
    done_a = 1'b0;
  endtask

  task automatic t_small;
    grant_b((NB'(1) << 19) | (NB'(1) << 5), 19, "R8 ch19 is level0");
    grant_b(NB'(1) << 12, 12, "R8 level3 alone");
    grant_b((NB'(1) << 2) | (NB'(1) << 18), 2, "R8 level0 wrap after 19");
  endtask

  initial begin
    t_reset();
    #22;
    rst_n = 1'b1;
    t_idle();
    t_priority();
    t_rr();
    t_hold();
    t_small();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule